// File: doc/BRIEF.md
# Decoder-Aided Symbol Timing Error Loop

This block is the fine tracking stage of a two-stage symbol timing recovery chain. It runs at the interpolated symbol rate. Each strobed symbol brings two inputs: a signed soft sample from the interpolator and the matching hard symbol that the channel decoder produced for that position. The reference is the decoded codeword symbol, not a slicer decision on the sample. From the current pair and the previous pair the block forms a timing error. It then adds a scaled copy of that error to a running correction.

The correction is a signed fixed-point fraction of a symbol period. A downstream interpolator uses it to steer its sampling phase, which removes random-walk timing drift and whatever delay or frequency error the coarse stage left behind. The loop is purely first order: the gain scales the error, the scaled error is accumulated, and there is no second integral path. A synchronous clear restarts the loop. This can be used at a block boundary or after the coarse stage has retuned.

Top module: `dec_ted_loop`

## Requirements
- R1: After reset is released, the error output and the correction output both read zero.
- R2: For a strobed symbol with sample s and reference bit r, and with a stored previous pair (sp, rp), the error is u = v(rp)·s − v(r)·sp. The mapping is v(0) = +1 and v(1) = −1. The error appears on the error output after the clock edge that captures the strobe.
- R3: The first strobed symbol after reset or after a clear produces an error of zero, and it leaves the correction unchanged.
- R4: Cycles without a strobe change neither the outputs nor the stored previous pair, whatever the sample and reference inputs carry.
- R5: Each strobed symbol updates the correction to c + floor(u·g / 2^GAIN_FRAC). Here g is the unsigned gain input.
- R6: When the update would exceed the largest positive correction, the correction holds at 2^(CORR_W−1)−1 and does not wrap.
- R7: When the update would fall below the most negative correction, the correction holds at −2^(CORR_W−1) and does not wrap.
- R8: A clear zeroes the error output, the correction and the stored previous pair on the next edge. The clear takes priority over a strobe in the same cycle.
- R9: With a gain of zero, strobed symbols leave the correction unchanged.
- R10: The reference sign comes only from the reference input. A sample whose sign disagrees with its reference bit is still multiplied by the sign of that reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of correction, error and history |
| smp_vld | input | 1 | Strobe marking a valid sample/reference pair |
| smp | input | SAMP_W | Signed interpolated soft sample |
| ref_sym | input | 1 | Decoded reference symbol, 0 = +1, 1 = −1 |
| gain | input | GAIN_W | Unsigned proportional gain, GAIN_FRAC fractional bits |
| err_o | output | SAMP_W+2 | Signed timing error of the last strobed symbol |
| corr_o | output | CORR_W | Signed saturating timing correction |

## Verification
The bench drives references that contradict the sample sign. A design that sliced the sample instead of using the reference would produce the wrong sign of error there. Idle gaps with changing inputs catch history or accumulator registers that load without a strobe; such a design would report an error against the wrong previous pair. Long runs of same-sign maximum errors drive the correction into both rails, where a wrapping adder would flip the correction's sign. Negative non-integer steps catch truncation toward zero. A clear raised together with a strobe catches a clear that loses priority, which would leave a stale pair and a non-zero first error.

// File: rtl/dtl_pkg.sv
package dtl_pkg;

  // One-bit encoding of a decoded antipodal symbol.
  typedef enum logic {
    SYM_PLUS  = 1'b0,
    SYM_MINUS = 1'b1
  } sym_e;

endpackage

// File: rtl/dtl_history.sv
module dtl_history #(
  parameter int SAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              vld,
  input  logic [SAMP_W-1:0] smp,
  input  logic              sym,
  output logic [SAMP_W-1:0] prev_smp,
  output logic              prev_sym,
  output logic              have_prev
);

  logic [SAMP_W-1:0] smp_d;
  logic              sym_d;
  logic              have_d;
  logic              hist_en;

  assign hist_en = clr | vld;

  always_comb begin
    smp_d  = prev_smp;
    sym_d  = prev_sym;
    have_d = have_prev;
    if (clr) begin
      smp_d  = '0;
      sym_d  = 1'b0;
      have_d = 1'b0;
    end else if (vld) begin
      smp_d  = smp;
      sym_d  = sym;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_smp  <= '0;
      prev_sym  <= 1'b0;
      have_prev <= 1'b0;
    end else if (hist_en) begin
      prev_smp  <= smp_d;
      prev_sym  <= sym_d;
      have_prev <= have_d;
    end
  end

  // History only moves on a strobe or a clear.
  p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !vld) |=> ($stable(prev_smp) && $stable(prev_sym) && $stable(have_prev)));

  p_hist_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!have_prev && prev_smp == '0));

endmodule

// File: rtl/dtl_ted.sv
module dtl_ted #(
  parameter int SAMP_W = 12,
  parameter int ERR_W  = SAMP_W + 2
) (
  input  logic [SAMP_W-1:0] smp,
  input  logic              sym,
  input  logic [SAMP_W-1:0] prev_smp,
  input  logic              prev_sym,
  input  logic              have_prev,
  output logic [ERR_W-1:0]  err
);

  logic signed [ERR_W-1:0] cur_x;
  logic signed [ERR_W-1:0] old_x;
  logic signed [ERR_W-1:0] cur_term;
  logic signed [ERR_W-1:0] old_term;

  assign cur_x = {{(ERR_W-SAMP_W){smp[SAMP_W-1]}}, smp};
  assign old_x = {{(ERR_W-SAMP_W){prev_smp[SAMP_W-1]}}, prev_smp};

  // Products with a +/-1 symbol collapse to a conditional negation.
  always_comb begin
    cur_term = (prev_sym == dtl_pkg::SYM_MINUS) ? -cur_x : cur_x;
    old_term = (sym == dtl_pkg::SYM_MINUS) ? -old_x : old_x;
    if (have_prev) begin
      err = cur_term - old_term;
    end else begin
      err = '0;
    end
  end

endmodule

// File: rtl/dtl_loop_acc.sv
module dtl_loop_acc #(
  parameter int ERR_W     = 14,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 8,
  parameter int CORR_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              vld,
  input  logic [ERR_W-1:0]  err,
  input  logic [GAIN_W-1:0] gain,
  output logic [ERR_W-1:0]  err_q,
  output logic [CORR_W-1:0] corr_q
);

  localparam int PROD_W = ERR_W + GAIN_W + 1;
  localparam int ACC_W  = ((CORR_W > PROD_W) ? CORR_W : PROD_W) + 1;
  localparam logic [ACC_W-1:0] CMAX = {{(ACC_W-CORR_W+1){1'b0}}, {(CORR_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] CMIN = {{(ACC_W-CORR_W+1){1'b1}}, {(CORR_W-1){1'b0}}};

  logic signed [PROD_W-1:0] err_x;
  logic signed [PROD_W-1:0] gain_x;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] step;
  logic signed [ACC_W-1:0]  step_x;
  logic signed [ACC_W-1:0]  corr_x;
  logic signed [ACC_W-1:0]  sum;
  logic [CORR_W-1:0]        corr_sat;
  logic [CORR_W-1:0]        corr_d;
  logic [ERR_W-1:0]         err_d;
  logic                     acc_en;

  assign err_x  = {{(PROD_W-ERR_W){err[ERR_W-1]}}, err};
  assign gain_x = {{(PROD_W-GAIN_W){1'b0}}, gain};
  assign prod   = err_x * gain_x;
  assign step   = prod >>> GAIN_FRAC;
  assign step_x = {{(ACC_W-PROD_W){step[PROD_W-1]}}, step};
  assign corr_x = {{(ACC_W-CORR_W){corr_q[CORR_W-1]}}, corr_q};
  assign sum    = corr_x + step_x;

  always_comb begin
    if (sum > $signed(CMAX)) begin
      corr_sat = CMAX[CORR_W-1:0];
    end else if (sum < $signed(CMIN)) begin
      corr_sat = CMIN[CORR_W-1:0];
    end else begin
      corr_sat = sum[CORR_W-1:0];
    end
  end

  assign acc_en = clr | vld;

  always_comb begin
    corr_d = corr_q;
    err_d  = err_q;
    if (clr) begin
      corr_d = '0;
      err_d  = '0;
    end else if (vld) begin
      corr_d = corr_sat;
      err_d  = err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= '0;
      err_q  <= '0;
    end else if (acc_en) begin
      corr_q <= corr_d;
      err_q  <= err_d;
    end
  end

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !vld) |=> ($stable(corr_q) && $stable(err_q)));

  p_no_wrap_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && vld && corr_q == CMAX[CORR_W-1:0] && !step[PROD_W-1])
      |=> (corr_q == CMAX[CORR_W-1:0]));

  p_no_wrap_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && vld && corr_q == CMIN[CORR_W-1:0] && (step[PROD_W-1] || step == '0))
      |=> (corr_q == CMIN[CORR_W-1:0]));

  p_zero_gain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && gain == '0) |=> $stable(corr_q));

endmodule

// File: rtl/dec_ted_loop.sv
module dec_ted_loop #(
  parameter int SAMP_W    = 12,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 8,
  parameter int CORR_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                smp_vld,
  input  logic [SAMP_W-1:0]   smp,
  input  logic                ref_sym,
  input  logic [GAIN_W-1:0]   gain,
  output logic [SAMP_W+1:0]   err_o,
  output logic [CORR_W-1:0]   corr_o
);

  localparam int ERR_W = SAMP_W + 2;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_n;
  logic rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_s_n    <= rst_meta_n;
    end
  end

  logic [SAMP_W-1:0] prev_smp;
  logic              prev_sym;
  logic              have_prev;
  logic [ERR_W-1:0]  err_now;

  dtl_history #(
    .SAMP_W (SAMP_W)
  ) u_hist (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clr       (clr),
    .vld       (smp_vld),
    .smp       (smp),
    .sym       (ref_sym),
    .prev_smp  (prev_smp),
    .prev_sym  (prev_sym),
    .have_prev (have_prev)
  );

  dtl_ted #(
    .SAMP_W (SAMP_W),
    .ERR_W  (ERR_W)
  ) u_ted (
    .smp       (smp),
    .sym       (ref_sym),
    .prev_smp  (prev_smp),
    .prev_sym  (prev_sym),
    .have_prev (have_prev),
    .err       (err_now)
  );

  dtl_loop_acc #(
    .ERR_W     (ERR_W),
    .GAIN_W    (GAIN_W),
    .GAIN_FRAC (GAIN_FRAC),
    .CORR_W    (CORR_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .clr    (clr),
    .vld    (smp_vld),
    .err    (err_now),
    .gain   (gain),
    .err_q  (err_o),
    .corr_q (corr_o)
  );

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    clr |=> (err_o == '0 && corr_o == '0));

  p_first_zero_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (smp_vld && !clr && !have_prev) |=> (err_o == '0 && $stable(corr_o)));

  // An unchanged pair carries no timing information.
  p_repeat_zero_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (smp_vld && !clr && have_prev && smp == prev_smp && ref_sym == prev_sym)
      |=> (err_o == '0));

endmodule

// File: tb/dec_ted_loop_tb.sv
`timescale 1ns/1ps
module dec_ted_loop_tb;

  localparam int SW = 12;
  localparam int GW = 8;
  localparam int GF = 8;
  localparam int CW = 16;
  localparam int EW = SW + 2;
  localparam int CMAX = (1 << (CW - 1)) - 1;
  localparam int CMIN = -(1 << (CW - 1));

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr;
  logic          smp_vld;
  logic [SW-1:0] smp;
  logic          ref_sym;
  logic [GW-1:0] gain;
  logic [EW-1:0] err_o;
  logic [CW-1:0] corr_o;

  always #4 clk = ~clk;

  dec_ted_loop #(
    .SAMP_W (SW), .GAIN_W (GW), .GAIN_FRAC (GF), .CORR_W (CW)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .clr (clr), .smp_vld (smp_vld),
    .smp (smp), .ref_sym (ref_sym), .gain (gain),
    .err_o (err_o), .corr_o (corr_o)
  );

  typedef struct {
    int    e;
    int    c;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  int   m_ps   = 0;
  bit   m_pr   = 0;
  bit   m_have = 0;
  int   m_corr = 0;
  int   m_err  = 0;

  function automatic int sgn(bit b);
    return b ? -1 : 1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic void model_reset();
    m_ps = 0; m_pr = 0; m_have = 0; m_corr = 0; m_err = 0;
  endfunction

  // Driver: called at posedge+1; holds the strobe across one edge.
  task automatic send(int s, bit r, string tag);
    int     u;
    longint p;
    longint nc;
    exp_t   x;
    u = m_have ? (sgn(m_pr) * s - sgn(r) * m_ps) : 0;
    p = longint'(u) * longint'(gain);
    nc = longint'(m_corr) + (p >>> GF);
    if (nc > CMAX) nc = CMAX;
    if (nc < CMIN) nc = CMIN;
    m_corr = int'(nc);
    m_err  = u;
    m_ps = s; m_pr = r; m_have = 1;
    x.e = u; x.c = m_corr; x.tag = tag;
    q.push_back(x);
    smp_vld = 1'b1;
    smp     = s[SW-1:0];
    ref_sym = r;
    @(posedge clk); #1;
  endtask

  task automatic idle(int n, int wig);
    smp_vld = 1'b0;
    for (int i = 0; i < n; i++) begin
      smp     = SW'(wig * (i + 3));
      ref_sym = i[0];
      @(posedge clk); #1;
    end
  endtask

  task automatic check_outputs(string tag, int e, int c);
    @(negedge clk);
    chk(int'($signed(err_o)) == e, tag, int'($signed(err_o)), e);
    chk(int'($signed(corr_o)) == c, tag, int'($signed(corr_o)), c);
    @(posedge clk); #1;
  endtask

  // Monitor: pops one expectation per captured strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (smp_vld && !clr) begin
        @(negedge clk);
        if (q.size() == 0) begin
          chk(1'b0, "SCOREBOARD", 0, 1);
        end else begin
          exp_t x;
          x = q.pop_front();
          chk(int'($signed(err_o)) == x.e, {x.tag, " err"}, int'($signed(err_o)), x.e);
          chk(int'($signed(corr_o)) == x.c, {x.tag, " corr"}, int'($signed(corr_o)), x.c);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; smp_vld = 1'b0; smp = '0; ref_sym = 1'b0;
    gain = 8'd64;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: outputs idle at zero after reset
    check_outputs("R1", 0, 0);

    // R3 first symbol, R2 error form, R10 reference against sample sign
    send(100, 0, "R3");
    send(-80, 1, "R2");
    send(300, 1, "R10");
    send(-500, 0, "R10");
    send(640, 0, "R2");
    // R4: idle cycles with moving inputs disturb nothing
    idle(5, 37);
    check_outputs("R4", m_err, m_corr);
    send(250, 1, "R4");

    // R9: zero gain freezes the correction
    gain = 8'd0;
    send(-900, 0, "R9");
    send(1200, 1, "R9");
    idle(1, 5);
    check_outputs("R9", m_err, m_corr);

    // R5: fractional gain with negative steps floors
    gain = 8'd200;
    send(-7, 0, "R5");
    send(13, 1, "R5");
    send(-1, 1, "R5");
    send(2, 0, "R5");
    send(-1999, 1, "R5");

    // R8: plain clear, then first symbol yields zero error (R3)
    smp_vld = 1'b0; clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0;
    model_reset();
    check_outputs("R8", 0, 0);
    send(700, 1, "R3");
    send(-20, 0, "R2");

    // R8: clear wins over a simultaneous strobe
    clr = 1'b1; smp_vld = 1'b1; smp = 12'd555; ref_sym = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0; smp_vld = 1'b0;
    model_reset();
    check_outputs("R8", 0, 0);
    send(123, 0, "R8");

    // R6: drive to the upper rail
    gain = 8'd255;
    for (int k = 0; k < 6; k++) begin
      send(2047, 0, "R6");
      send(2047, 1, "R6");
      send(-2048, 1, "R6");
      send(-2048, 0, "R6");
    end
    idle(1, 1);
    check_outputs("R6", m_err, CMAX);

    // R7: drive to the lower rail
    for (int k = 0; k < 6; k++) begin
      send(2047, 1, "R7");
      send(2047, 0, "R7");
      send(-2048, 0, "R7");
      send(-2048, 1, "R7");
    end
    idle(1, 1);
    check_outputs("R7", m_err, CMIN);

    idle(3, 2);
    chk(q.size() == 0, "SCOREBOARD", q.size(), 0);
    report();
  end

endmodule